// File: doc/BRIEF.md
# Receive Descriptor Ownership Manager

This block sits beside the receive path of an Ethernet MAC and walks a ring of two-word receive descriptors held in system memory. A queue pointer names the descriptor that the next frame will use. When a frame starts, the block reads that descriptor's first word. If software still owns the descriptor, the block refuses the frame and reports that no buffer is available. Otherwise it follows the frame to its end. When the frame ends well, it writes the length and the address-filter match reason into the second word, hands ownership to software in the first word, raises a receive-complete event and moves the pointer on.

Frames that end with an error are dropped without any memory write or completion event, and a saturating error counter is incremented. The payload DMA is modelled only by a per-beat ready signal. A data beat that arrives while that signal is low is an overrun. An overrun abandons the frame and leaves the descriptor with hardware for the next frame.

Each descriptor is two 32-bit words, 8 bytes apart. Word 0 holds the buffer address, with an ownership flag in bit 0 (1 = software) and a wrap flag in bit 1. Word 1 receives the status. Software returns a buffer by writing bit 0 of word 0 back to 0.

Top module: `rx_desc_owner`

## Requirements
- R1: After reset `qptr` is 0, `bad_cnt` is 0 and no event is raised. A `qp_init` pulse loads `qptr` with `ring_base`.
- R2: On `frm_start` the block reads word 0 at `qptr`. If bit 0 of that word is 1, `ev_no_buf` pulses for one cycle, nothing is written and `qptr` keeps its value.
- R3: A good frame on a hardware-owned descriptor writes word 1 (address `qptr`+4) with the length in bits 15:0, the match reason in bits 18:16 and zeros elsewhere. It then rewrites word 0 with bit 0 set and all other bits kept.
- R4: `ev_rx_done` pulses for exactly one cycle per stored frame, in the cycle right after the word 0 write-back.
- R5: After a stored frame `qptr` advances by 8. If bit 1 of the used word 0 is 1, `qptr` returns to `ring_base` instead. At no other time does `qptr` change, apart from `qp_init`.
- R6: A data beat while `dma_ready` is low during storage raises `ev_overrun` for one cycle. The frame is then abandoned: no write, no `ev_rx_done`, and `qptr` unchanged.
- R7: A frame that ends with `frm_good` low increments `bad_cnt` by one. It causes no memory write, no `ev_rx_done`, and leaves `qptr` unchanged.
- R8: `bad_cnt` saturates at its all-ones value.
- R9: At most one of `ev_rx_done`, `ev_no_buf`, `ev_overrun` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Byte address of the first descriptor of the ring |
| qp_init | input | 1 | Load the queue pointer from `ring_base` |
| frm_start | input | 1 | Pulse: a frame begins |
| frm_end | input | 1 | Pulse: the frame ends |
| frm_good | input | 1 | With `frm_end`: frame received without error |
| frm_len | input | LW | With `frm_end`: frame length in bytes |
| match_why | input | MRW | With `frm_end`: address-filter match reason |
| data_beat | input | 1 | A payload beat arrives from the MAC |
| dma_ready | input | 1 | Payload DMA can accept the current beat |
| mem_re | output | 1 | Descriptor read strobe (data one cycle later) |
| mem_we | output | 1 | Descriptor write strobe |
| mem_addr | output | AW | Descriptor word byte address |
| mem_wdata | output | 32 | Descriptor write data |
| mem_rdata | input | 32 | Descriptor read data, valid the cycle after `mem_re` |
| qptr | output | AW | Queue pointer: next descriptor address |
| ev_rx_done | output | 1 | Event: frame stored and descriptor handed over |
| ev_no_buf | output | 1 | Event: next descriptor still owned by software |
| ev_overrun | output | 1 | Event: payload DMA could not keep up |
| bad_cnt | output | CW | Saturating count of frames ending in error |

## Verification
The bench sweeps every match reason against four frame outcomes: a clean store, a descriptor still owned by software, an error frame and a DMA stall. Comparing event counts, memory contents and pointer position tells each refusal path apart from a store. The clean stores cycle through a four-entry ring whose last entry carries the wrap flag, so both the step-by-8 and the return-to-base moves of the pointer are checked. Stored status words carry a distinct reason and length each time, which exposes misplaced or mixed-up fields. A final run of error frames with a 4-bit counter drives the counter past its top and checks that it holds there.

// File: rtl/rx_desc_pkg.sv
// Shared types and layout constants for the receive descriptor manager.
// Assumes 32-bit descriptor words, two words per descriptor.
package rx_desc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a frame start
        ST_FETCH,  // descriptor word 0 arriving
        ST_RECV,   // storing payload
        ST_DROP,   // ignoring the rest of a refused or overrun frame
        ST_WB1,    // writing status word
        ST_WB0,    // handing ownership to software
        ST_CMPL    // completion event, pointer advance
    } rxd_state_e;

    localparam int OWN_BIT     = 0;
    localparam int WRAP_BIT    = 1;
    localparam int DESC_BYTES  = 8;
    localparam int WORD1_OFS   = 4;
    localparam int REASON_LSB  = 16;
endpackage

// File: rtl/rx_qptr.sv
// Queue pointer register: loaded from the ring base on request, stepped by one
// descriptor or wrapped to the base after each stored frame.
// Assumes load and advance never coincide.
module rx_qptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          load,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] qptr
);
    import rx_desc_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    // Pointer update: reset, load, or advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    qptr <= '0;
        else if (load) qptr <= ring_base;
        else if (adv)  qptr <= wrap ? ring_base : qptr + STEP;
    end
endmodule

// File: rtl/rx_stat_cnt.sv
// Saturating event counter for frames dropped because of receive errors.
// Assumes a single-cycle increment strobe.
module rx_stat_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = '1;

    // Count up on each strobe, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_desc_fsm.sv
// Frame sequencer: fetches the descriptor at frame start, tracks the frame,
// writes status and ownership back for good frames, and raises events.
// Assumes frm_end and the first data beat come at least two cycles after
// frm_start, the next frm_start comes at least four cycles after frm_end,
// and LW <= 16, MRW <= 16.
module rx_desc_fsm #(
    parameter int AW  = 32,
    parameter int LW  = 14,
    parameter int MRW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  qptr,
    input  logic           frm_start,
    input  logic           frm_end,
    input  logic           frm_good,
    input  logic [LW-1:0]  frm_len,
    input  logic [MRW-1:0] match_why,
    input  logic           data_beat,
    input  logic           dma_ready,
    input  logic [31:0]    mem_rdata,
    output logic           mem_re,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    output logic           adv,
    output logic           wrap,
    output logic           bad_inc,
    output logic           ev_rx_done,
    output logic           ev_no_buf,
    output logic           ev_overrun
);
    import rx_desc_pkg::*;

    rxd_state_e     st, st_nx;
    logic [31:0]    w0_q;
    logic [LW-1:0]  len_q;
    logic [MRW-1:0] why_q;
    logic           stall;
    logic [31:0]    status_w;

    assign stall    = (st == ST_RECV) && data_beat && !dma_ready;
    assign status_w = 32'(len_q) | (32'(why_q) << REASON_LSB);

    // State register plus captured descriptor word and end-of-frame status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            w0_q  <= '0;
            len_q <= '0;
            why_q <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_FETCH) w0_q <= mem_rdata;
            if (st == ST_RECV && frm_end) begin
                len_q <= frm_len;
                why_q <= match_why;
            end
        end
    end

    // Next-state selection.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (frm_start) st_nx = ST_FETCH;
            ST_FETCH: st_nx = mem_rdata[OWN_BIT] ? ST_DROP : ST_RECV;
            ST_RECV: begin
                if (frm_end)    st_nx = (frm_good && !stall) ? ST_WB1 : ST_IDLE;
                else if (stall) st_nx = ST_DROP;
            end
            ST_DROP:  if (frm_end) st_nx = ST_IDLE;
            ST_WB1:   st_nx = ST_WB0;
            ST_WB0:   st_nx = ST_CMPL;
            ST_CMPL:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Memory port and event outputs decoded from the state.
    always_comb begin
        mem_re     = (st == ST_IDLE) && frm_start;
        mem_we     = (st == ST_WB1) || (st == ST_WB0);
        mem_addr   = (st == ST_WB1) ? qptr + AW'(WORD1_OFS) : qptr;
        mem_wdata  = (st == ST_WB1) ? status_w : (w0_q | (32'd1 << OWN_BIT));
        adv        = (st == ST_CMPL);
        wrap       = w0_q[WRAP_BIT];
        bad_inc    = frm_end && !frm_good && ((st == ST_RECV) || (st == ST_DROP));
        ev_rx_done = (st == ST_CMPL);
        ev_no_buf  = (st == ST_FETCH) && mem_rdata[OWN_BIT];
        ev_overrun = stall;
    end
endmodule

// File: rtl/rx_desc_owner_chk.sv
// Property checker for the receive descriptor manager, bound to the top.
module rx_desc_owner_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          qp_init,
    input logic          mem_re,
    input logic          mem_we,
    input logic          mem_a2,
    input logic          mem_own,
    input logic [AW-1:0] qptr,
    input logic          ev_rx_done,
    input logic          ev_no_buf,
    input logic          ev_overrun,
    input logic [CW-1:0] bad_cnt
);
    // R9
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_rx_done, ev_no_buf, ev_overrun}));
    // R4
    done_after_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |-> $past(mem_we && !mem_a2));
    // R3
    handover_sets_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_a2) |-> mem_own);
    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_rx_done && !qp_init) |=> $stable(qptr));
    // R2
    nobuf_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_no_buf |-> $past(mem_re));
    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bad_cnt == $past(bad_cnt) || bad_cnt == $past(bad_cnt) + 1'b1));
    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cnt == '1) |=> (bad_cnt == '1));
endmodule

bind rx_desc_owner rx_desc_owner_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .qp_init    (qp_init),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_a2     (mem_addr[2]),
    .mem_own    (mem_wdata[0]),
    .qptr       (qptr),
    .ev_rx_done (ev_rx_done),
    .ev_no_buf  (ev_no_buf),
    .ev_overrun (ev_overrun),
    .bad_cnt    (bad_cnt)
);

// File: rtl/rx_desc_owner.sv
// Top of the receive descriptor ownership manager: sequencer, queue pointer
// and error counter. Assumes ring_base is 8-byte aligned and qp_init is only
// pulsed between frames.
module rx_desc_owner #(
    parameter int AW  = 32,
    parameter int LW  = 14,
    parameter int MRW = 3,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  ring_base,
    input  logic           qp_init,
    input  logic           frm_start,
    input  logic           frm_end,
    input  logic           frm_good,
    input  logic [LW-1:0]  frm_len,
    input  logic [MRW-1:0] match_why,
    input  logic           data_beat,
    input  logic           dma_ready,
    output logic           mem_re,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    output logic [AW-1:0]  qptr,
    output logic           ev_rx_done,
    output logic           ev_no_buf,
    output logic           ev_overrun,
    output logic [CW-1:0]  bad_cnt
);
    logic adv, wrap, bad_inc;

    rx_desc_fsm #(.AW(AW), .LW(LW), .MRW(MRW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .qptr       (qptr),
        .frm_start  (frm_start),
        .frm_end    (frm_end),
        .frm_good   (frm_good),
        .frm_len    (frm_len),
        .match_why  (match_why),
        .data_beat  (data_beat),
        .dma_ready  (dma_ready),
        .mem_rdata  (mem_rdata),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .adv        (adv),
        .wrap       (wrap),
        .bad_inc    (bad_inc),
        .ev_rx_done (ev_rx_done),
        .ev_no_buf  (ev_no_buf),
        .ev_overrun (ev_overrun)
    );

    rx_qptr #(.AW(AW)) u_qptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .load      (qp_init),
        .adv       (adv),
        .wrap      (wrap),
        .qptr      (qptr)
    );

    rx_stat_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bad_inc),
        .cnt   (bad_cnt)
    );
endmodule

// File: tb/rx_desc_owner_bench.sv
`timescale 1ns/1ps
module rx_desc_owner_bench;
    localparam int AW = 32, LW = 14, MRW = 3, CW = 4;
    localparam logic [AW-1:0] BASE = 32'h0000_0100;

    logic           clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0]  ring_base = BASE;
    logic           qp_init = 0, frm_start = 0, frm_end = 0, frm_good = 0;
    logic [LW-1:0]  frm_len = '0;
    logic [MRW-1:0] match_why = '0;
    logic           data_beat = 0, dma_ready = 1;
    logic           mem_re, mem_we;
    logic [AW-1:0]  mem_addr, qptr;
    logic [31:0]    mem_wdata, mem_rdata;
    logic           ev_rx_done, ev_no_buf, ev_overrun;
    logic [CW-1:0]  bad_cnt;

    int total = 0, bad = 0;
    int n_done = 0, n_nobuf = 0, n_ovr = 0, n_wr = 0, ord_bad = 0;
    int cyc = 0, last_w0 = -10;
    logic [31:0] bmem [8];

    always #2 clk = ~clk;

    rx_desc_owner #(.AW(AW), .LW(LW), .MRW(MRW), .CW(CW)) u_rx_desc_owner (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .qp_init(qp_init),
        .frm_start(frm_start), .frm_end(frm_end), .frm_good(frm_good),
        .frm_len(frm_len), .match_why(match_why), .data_beat(data_beat),
        .dma_ready(dma_ready), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .qptr(qptr), .ev_rx_done(ev_rx_done), .ev_no_buf(ev_no_buf),
        .ev_overrun(ev_overrun), .bad_cnt(bad_cnt)
    );

    function automatic int widx(input logic [AW-1:0] a);
        return int'((a - BASE) >> 2) & 7;
    endfunction

    // Descriptor memory model: one-cycle read latency, single-cycle writes.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) mem_rdata <= bmem[widx(mem_addr)];
        if (mem_we) bmem[widx(mem_addr)] <= mem_wdata;
    end

    // Event and write monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) n_wr++;
            if (mem_we && !mem_addr[2]) last_w0 = cyc;
            if (ev_no_buf) n_nobuf++;
            if (ev_overrun) n_ovr++;
            if (ev_rx_done) begin
                n_done++;
                if (last_w0 != cyc - 1) ord_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // scn: 0 store, 1 software-owned, 2 error frame, 3 DMA stall
    task automatic run_frame(input int scn, input int why, inout int slot, inout int ecnt);
        int d0 = n_done, dn = n_nobuf, dv = n_ovr, dw = n_wr, ob = ord_bad;
        logic [31:0] w0;
        logic [LW-1:0] len = LW'(64 + why * 7 + scn);
        w0 = 32'h0001_0000 + 32'(slot) * 32'h100 + ((slot == 3) ? 32'h2 : 32'h0)
             + ((scn == 1) ? 32'h1 : 32'h0);
        bmem[2*slot] = w0;
        bmem[2*slot+1] = 32'hDEAD_0000;
        frm_start = 1; tick(); frm_start = 0; tick();
        for (int b = 0; b < 3; b++) begin
            data_beat = 1; dma_ready = !(scn == 3 && b == 1); tick();
        end
        data_beat = 0; dma_ready = 1;
        frm_end = 1; frm_good = (scn != 2); frm_len = len; match_why = MRW'(why);
        tick(); frm_end = 0;
        repeat (5) tick();
        if (scn == 0) begin
            chk(n_done == d0 + 1, "R4 done pulse", n_done - d0, 1);
            chk(ord_bad == ob, "R4 done after word0", ord_bad - ob, 0);
            chk(bmem[2*slot+1] == ((32'(why) << 16) | 32'(len)), "R3 status word",
                bmem[2*slot+1], (32'(why) << 16) | 32'(len));
            chk(bmem[2*slot] == (w0 | 32'h1), "R3 ownership", bmem[2*slot], w0 | 32'h1);
            slot = (slot == 3) ? 0 : slot + 1;
            bmem[0] = bmem[0];
        end else begin
            chk(n_wr == dw, "R2/R6/R7 no write", n_wr - dw, 0);
            chk(n_done == d0, "R2/R6/R7 no done", n_done - d0, 0);
        end
        if (scn == 1) chk(n_nobuf == dn + 1, "R2 no-buffer event", n_nobuf - dn, 1);
        else          chk(n_nobuf == dn, "R2 no spurious no-buffer", n_nobuf - dn, 0);
        if (scn == 3) chk(n_ovr == dv + 1, "R6 overrun event", n_ovr - dv, 1);
        else          chk(n_ovr == dv, "R6 no spurious overrun", n_ovr - dv, 0);
        if (scn == 2) ecnt = (ecnt == 15) ? 15 : ecnt + 1;
        chk(int'(bad_cnt) == ecnt, "R7/R8 error count", bad_cnt, ecnt);
        chk(qptr == BASE + 32'(slot) * 8, "R5 pointer", qptr, BASE + 32'(slot) * 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d", 200000, 200000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int slot = 0, ecnt = 0;
        for (int i = 0; i < 8; i++) bmem[i] = '0;
        mem_rdata = '0;
        repeat (3) tick();
        rst_n = 1; tick();
        // R1 reset state
        chk(qptr == 0, "R1 pointer after reset", qptr, 0);
        chk(bad_cnt == 0, "R1 counter after reset", bad_cnt, 0);
        chk(!ev_rx_done && !ev_no_buf && !ev_overrun, "R1 events idle",
            {ev_rx_done, ev_no_buf, ev_overrun}, 0);
        qp_init = 1; tick(); qp_init = 0;
        chk(qptr == BASE, "R1 pointer load", qptr, BASE);
        // Sweep reasons against outcomes; R9 covered by the bound checker.
        for (int why = 0; why < 8; why++)
            for (int scn = 0; scn < 4; scn++)
                run_frame(scn, why, slot, ecnt);
        // R8 counter saturation
        for (int k = 0; k < 10; k++) run_frame(2, k & 7, slot, ecnt);
        chk(bad_cnt == 4'hF, "R8 saturated", bad_cnt, 15);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule